// File: doc/BRIEF.md
# Three-Sample Switch Debouncer with Edge-Filtered Change Flags

This block cleans up a group of six mechanical switch inputs on a lamp controller: two turn-request buttons, a cancel button, the brake switch, the engine-on line and the hazard button. A periodic tick, supplied from outside, strobes the raw levels into a short sample history. A level is accepted only once every stored sample agrees. The accepted levels are presented as a debounced state vector.

Each time the accepted level of an input changes, the block raises a change flag for that input. The flag is filtered by input type. Momentary buttons report only their press. Brake and engine-on report both press and release. The cancel flag is also withheld while a separate steering-rotation sense input reports that the wheel is turning in the same direction as the active signal.

Downstream logic reads the flags once per tick interval and folds them into its own lamp and timeout state. After reset the block assumes the engine is on and presents an engine flag, so that a downstream timeout counter reloads straight away.

Top module: `switch_debounce_top`

## Requirements
- R1: Raw inputs are captured only on a cycle where `tick` is high. Raw activity between ticks affects neither output.
- R2: A new level is accepted only when the newest three captured samples of an input are equal. A level present for fewer than three consecutive ticks changes neither `sw_level` nor `sw_toggle`.
- R3: When an input shows a new level on three consecutive ticks, `sw_level` takes that level one clock after the third tick. Inputs that are still unsettled keep their previous level.
- R4: Bit positions in `sw_raw`, `sw_level` and `sw_toggle` are as follows: left 0, right 1, brake 2, engine-on 3, hazard 4, cancel 5. For left, right, hazard and cancel, an accepted 0-to-1 change sets the matching `sw_toggle` bit. An accepted 1-to-0 change sets no bit.
- R5: For brake (bit 2) and engine-on (bit 3), any accepted change sets the matching `sw_toggle` bit, in either direction.
- R6: If `same_dir_rot` is high on the tick that completes a cancel press, `sw_toggle` bit 5 stays 0. `sw_level` bit 5 still updates.
- R7: `sw_toggle` is recomputed one clock after every tick and then holds until the next tick. A tick that brings no accepted change clears it.
- R8: Synchronous reset loads every captured sample and `sw_level` with 0x08 (engine-on only). It also loads `sw_toggle` with 0x08.
- R9: Inputs that settle on the same tick each raise their own flag in that tick's `sw_toggle`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-clock sampling strobe |
| sw_raw | input | 6 | Raw switch levels, active high |
| same_dir_rot | input | 1 | Steering rotation matches the active turn direction |
| sw_level | output | 6 | Debounced switch levels |
| sw_toggle | output | 6 | Filtered change flags, valid for one tick interval |

## Verification
On every cycle, the embedded properties check the following:
- The sample history and the outputs move only on a tick or one clock after it.
- Unsettled bits never change level.
- No release flag appears for a button-type input.
- Brake and engine flags match their level changes exactly.
- Cancel stays quiet under same-direction rotation.

Only the bench scenarios can show the three-tick acceptance count, the rejection of short bounce trains and the exact reset values. These are absolute values and tick counts that the cycle-local properties do not pin down.

// File: rtl/dbc_pkg.sv
package dbc_pkg;
  localparam int unsigned SW_W     = 6;
  localparam int unsigned B_LEFT   = 0;
  localparam int unsigned B_RIGHT  = 1;
  localparam int unsigned B_BRAKE  = 2;
  localparam int unsigned B_ENGINE = 3;
  localparam int unsigned B_HAZARD = 4;
  localparam int unsigned B_CANCEL = 5;

  typedef logic [SW_W-1:0] sw_vec_t;

  localparam sw_vec_t BOTH_EDGE_DEF = sw_vec_t'((1 << B_BRAKE) | (1 << B_ENGINE));
  localparam sw_vec_t RESET_LVL_DEF = sw_vec_t'(1 << B_ENGINE);
endpackage

// File: rtl/dbc_sample_chain.sv
// Shift history of raw samples, advanced on each tick; reports per-bit agreement.
module dbc_sample_chain #(
  parameter int unsigned N       = 6,
  parameter int unsigned DEPTH   = 3,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] raw,
  output logic [N-1:0] newest,
  output logic [N-1:0] agree
);
  logic [N-1:0] smp [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) smp[0] <= RST_VAL;
    else if (tick) smp[0] <= raw;
  end

  genvar k;
  generate
    for (k = 1; k < DEPTH; k++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) smp[k] <= RST_VAL;
        else if (tick) smp[k] <= smp[k-1];
      end
    end
  endgenerate

  always_comb begin
    agree = '1;
    for (int j = 1; j < DEPTH; j++) agree = agree & ~(smp[j] ^ smp[j-1]);
  end

  assign newest = smp[0];

  p_chain_hold_r1: assert property (@(posedge clk) disable iff (rst)
    !tick |=> (newest == $past(newest)));
  p_chain_load_r1: assert property (@(posedge clk) disable iff (rst)
    tick |=> (newest == $past(raw)));
endmodule

// File: rtl/dbc_level_track.sv
// Debounced level register: settled bits follow the newest sample.
module dbc_level_track #(
  parameter int unsigned N       = 6,
  parameter logic [N-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         eval,
  input  logic [N-1:0] newest,
  input  logic [N-1:0] agree,
  output logic [N-1:0] level,
  output logic [N-1:0] chg
);
  assign chg = agree & (newest ^ level);

  always_ff @(posedge clk) begin
    if (rst) level <= RST_VAL;
    else if (eval) level <= (level & ~agree) | (newest & agree);
  end

  p_level_only_eval_r3: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(level));
  p_unsettled_keep_r2: assert property (@(posedge clk) disable iff (rst)
    eval |=> (((level ^ $past(level)) & ~$past(agree)) == '0));
endmodule

// File: rtl/dbc_edge_filter.sv
// Per-input edge selection and cancel suppression; result held until next eval.
module dbc_edge_filter #(
  parameter int unsigned N          = 6,
  parameter logic [N-1:0] BOTH_MASK  = '0,
  parameter int unsigned CANCEL_IDX = 5,
  parameter logic [N-1:0] RST_TOG    = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         eval,
  input  logic [N-1:0] chg,
  input  logic [N-1:0] newest,
  input  logic         suppress,
  output logic [N-1:0] toggle
);
  logic [N-1:0] kept;

  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_bit
      logic edge_ok;
      if (BOTH_MASK[i]) begin : g_both
        assign edge_ok = chg[i];
      end else begin : g_press
        assign edge_ok = chg[i] & newest[i];
      end
      if (i == CANCEL_IDX) begin : g_cancel
        assign kept[i] = edge_ok & ~suppress;
      end else begin : g_plain
        assign kept[i] = edge_ok;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) toggle <= RST_TOG;
    else if (eval) toggle <= kept;
  end

  p_cancel_quiet_r6: assert property (@(posedge clk) disable iff (rst)
    (eval && suppress) |=> !toggle[CANCEL_IDX]);
  p_toggle_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !eval |=> $stable(toggle));
endmodule

// File: rtl/switch_debounce_top.sv
module switch_debounce_top #(
  parameter int unsigned N          = dbc_pkg::SW_W,
  parameter int unsigned DEPTH      = 3,
  parameter int unsigned CANCEL_IDX = dbc_pkg::B_CANCEL,
  parameter logic [N-1:0] BOTH_MASK  = dbc_pkg::BOTH_EDGE_DEF,
  parameter logic [N-1:0] RST_LEVEL  = dbc_pkg::RESET_LVL_DEF
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [N-1:0] sw_raw,
  input  logic         same_dir_rot,
  output logic [N-1:0] sw_level,
  output logic [N-1:0] sw_toggle
);
  logic         eval_q;
  logic         sd_q;
  logic [N-1:0] newest;
  logic [N-1:0] agree;
  logic [N-1:0] chg;

  always_ff @(posedge clk) begin
    if (rst) begin
      eval_q <= 1'b0;
      sd_q   <= 1'b0;
    end else begin
      eval_q <= tick;
      if (tick) sd_q <= same_dir_rot;
    end
  end

  dbc_sample_chain #(.N(N), .DEPTH(DEPTH), .RST_VAL(RST_LEVEL)) u_chain (
    .clk(clk), .rst(rst), .tick(tick), .raw(sw_raw),
    .newest(newest), .agree(agree)
  );

  dbc_level_track #(.N(N), .RST_VAL(RST_LEVEL)) u_level (
    .clk(clk), .rst(rst), .eval(eval_q), .newest(newest), .agree(agree),
    .level(sw_level), .chg(chg)
  );

  dbc_edge_filter #(.N(N), .BOTH_MASK(BOTH_MASK), .CANCEL_IDX(CANCEL_IDX),
                    .RST_TOG(RST_LEVEL)) u_edge (
    .clk(clk), .rst(rst), .eval(eval_q), .chg(chg), .newest(newest),
    .suppress(sd_q), .toggle(sw_toggle)
  );

  p_release_dropped_r4: assert property (@(posedge clk) disable iff (rst)
    (sw_toggle & ~BOTH_MASK & ~sw_level) == '0);
  p_both_edges_r5: assert property (@(posedge clk) disable iff (rst)
    eval_q |=> (((sw_level ^ $past(sw_level)) & BOTH_MASK) == (sw_toggle & BOTH_MASK)));
  p_flag_needs_change_r9: assert property (@(posedge clk) disable iff (rst)
    eval_q |=> ((sw_toggle & ~(sw_level ^ $past(sw_level))) == '0));
endmodule

// File: tb/switch_debounce_top_tb.sv
module switch_debounce_top_tb;
  localparam int CLK_NS = 4;
  localparam int NVEC   = 44;
  // {same_dir, raw, expected level, expected toggle}
  localparam logic [18:0] VEC [NVEC] = '{
    {1'b0,6'h08,6'h08,6'h00}, {1'b0,6'h09,6'h08,6'h00}, {1'b0,6'h09,6'h08,6'h00},
    {1'b0,6'h09,6'h09,6'h01}, {1'b0,6'h09,6'h09,6'h00}, {1'b0,6'h08,6'h09,6'h00},
    {1'b0,6'h08,6'h09,6'h00}, {1'b0,6'h08,6'h08,6'h00}, {1'b0,6'h0C,6'h08,6'h00},
    {1'b0,6'h08,6'h08,6'h00}, {1'b0,6'h0C,6'h08,6'h00}, {1'b0,6'h08,6'h08,6'h00},
    {1'b0,6'h08,6'h08,6'h00}, {1'b0,6'h08,6'h08,6'h00}, {1'b0,6'h0C,6'h08,6'h00},
    {1'b0,6'h0C,6'h08,6'h00}, {1'b0,6'h0C,6'h0C,6'h04}, {1'b0,6'h08,6'h0C,6'h00},
    {1'b0,6'h08,6'h0C,6'h00}, {1'b0,6'h08,6'h08,6'h04}, {1'b0,6'h00,6'h08,6'h00},
    {1'b0,6'h00,6'h08,6'h00}, {1'b0,6'h00,6'h00,6'h08}, {1'b0,6'h08,6'h00,6'h00},
    {1'b0,6'h08,6'h00,6'h00}, {1'b0,6'h08,6'h08,6'h08}, {1'b1,6'h28,6'h08,6'h00},
    {1'b1,6'h28,6'h08,6'h00}, {1'b1,6'h28,6'h28,6'h00}, {1'b0,6'h08,6'h28,6'h00},
    {1'b0,6'h08,6'h28,6'h00}, {1'b0,6'h08,6'h08,6'h00}, {1'b0,6'h28,6'h08,6'h00},
    {1'b0,6'h28,6'h08,6'h00}, {1'b0,6'h28,6'h28,6'h20}, {1'b0,6'h08,6'h28,6'h00},
    {1'b0,6'h08,6'h28,6'h00}, {1'b0,6'h08,6'h08,6'h00}, {1'b0,6'h1A,6'h08,6'h00},
    {1'b0,6'h1A,6'h08,6'h00}, {1'b0,6'h1A,6'h1A,6'h12}, {1'b0,6'h08,6'h1A,6'h00},
    {1'b0,6'h08,6'h1A,6'h00}, {1'b0,6'h08,6'h08,6'h00}
  };

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tick = 1'b0;
  logic [5:0] sw_raw = 6'h00;
  logic       same_dir_rot = 1'b0;
  logic [5:0] sw_level;
  logic [5:0] sw_toggle;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #(CLK_NS/2) clk = ~clk;

  switch_debounce_top u_dut (
    .clk(clk), .rst(rst), .tick(tick), .sw_raw(sw_raw),
    .same_dir_rot(same_dir_rot), .sw_level(sw_level), .sw_toggle(sw_toggle)
  );

  task automatic check(input string req, input logic [5:0] act, input logic [5:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic [5:0] raw, input logic sd);
    @(negedge clk);
    sw_raw = raw; same_dir_rot = sd; tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    pulse_reset();
    check("R8 level after reset", sw_level, 6'h08);
    check("R8 toggle after reset", sw_toggle, 6'h08);

    for (int i = 0; i < NVEC; i++) begin
      do_tick(VEC[i][17:12], VEC[i][18]);
      check($sformatf("R2 R3 R4 R5 R6 R9 level vec %0d", i), sw_level, VEC[i][11:6]);
      check($sformatf("R2 R4 R5 R6 R7 R9 toggle vec %0d", i), sw_toggle, VEC[i][5:0]);
    end

    // R1: raw activity with no tick is invisible
    @(negedge clk); sw_raw = 6'h3F;
    for (int c = 0; c < 10; c++) @(negedge clk);
    check("R1 level without tick", sw_level, 6'h08);
    check("R1 toggle without tick", sw_toggle, 6'h00);
    sw_raw = 6'h08;
    for (int t = 0; t < 3; t++) begin
      do_tick(6'h08, 1'b0);
      check("R1 no change after untick activity", sw_toggle, 6'h00);
    end

    // R7: flag held across the tick interval, then cleared
    do_tick(6'h0C, 1'b0); do_tick(6'h0C, 1'b0); do_tick(6'h0C, 1'b0);
    check("R7 brake flag raised", sw_toggle, 6'h04);
    for (int c = 0; c < 6; c++) @(negedge clk);
    check("R7 flag held between ticks", sw_toggle, 6'h04);
    do_tick(6'h0C, 1'b0);
    check("R7 flag cleared next tick", sw_toggle, 6'h00);

    // R8: reset mid-run, then engine falls from the reset level
    @(negedge clk); sw_raw = 6'h00;
    pulse_reset();
    check("R8 level after mid reset", sw_level, 6'h08);
    check("R8 toggle after mid reset", sw_toggle, 6'h08);
    do_tick(6'h00, 1'b0);
    check("R7 reset flag cleared by tick", sw_toggle, 6'h00);
    check("R2 level after one tick", sw_level, 6'h08);
    do_tick(6'h00, 1'b0);
    check("R2 level after two ticks", sw_level, 6'h08);
    do_tick(6'h00, 1'b0);
    check("R3 level after three ticks", sw_level, 6'h00);
    check("R5 engine release flag", sw_toggle, 6'h08);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_NS * 200000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule